// File: doc/BRIEF.md
# Pointer-Register Line Tag Store

This block holds the tags of two small line buffers that sit in front of memory: one bank of lines that serves instruction fetch for jumps, and one bank that serves loads and stores. Each line carries a line address and the number of the pointer register that the line was filled for. During decode, the pointer-register field of the current instruction is compared against every tag of the relevant bank in the same cycle. The decoder learns at once whether the data it needs is already buffered, which line holds it, and the line's address, without waiting for the register to be read or translated.

A hit on a memory or jump instruction lets the instruction issue. A miss raises a prefetch request, so that decode can insert a fill for the pointer. Fills come back as allocation requests carrying a register number and a line address. The block chooses the line to fill. Lines are grouped in pairs, and a pair belongs to one register at a time. A register that already owns a pair is double-buffered inside it, alternating between its two lines, so a long linear scan never pushes other pointers out. A register that owns no pair takes the pair that was allocated least recently. A task switch flushes every tag.

Top module: `lbt_tagstore`

## Requirements
- R1: With dec_class = 01 (load/store), dec_reg is compared in the same cycle against all load/store line tags. On a match, hit = 1, hit_line gives the line index (0 to 7) and hit_addr gives that line's stored address. On a miss, hit, hit_line and hit_addr are all 0.
- R2: dec_class = 10 (jump) searches only the fetch lines, which have indices 8 to 15. Load/store class searches only lines 0 to 7. Classes 00 and 11 search nothing and give hit = 0.
- R3: issue_ok is 1 exactly when a load/store or jump lookup hits.
- R4: prefetch_req is 1 exactly when a load/store or jump lookup misses. It is never 1 for classes 00 or 11.
- R5: An allocation (alloc_en = 1) writes alloc_reg and alloc_addr into the line shown on victim_line, and the write takes effect at the next rising clock edge. alloc_fetch = 1 selects the fetch bank. victim_line is combinational: its MSB equals alloc_fetch and its low three bits give the line within the bank. Lines 2k and 2k+1 form pair k.
- R6: If alloc_reg is not tagged in any valid line of the selected bank, the allocation goes to the even line of the least recently allocated pair, and the odd line of that pair is invalidated. After reset, the pairs are used in the order 0, 1, 2, 3.
- R7: If alloc_reg is already tagged in a pair of the selected bank, the allocation goes to whichever line of that pair was not written most recently.
- R8: When both lines of a pair hold the looked-up register, the lookup reports the line written most recently.
- R9: flush invalidates all 16 tags at the next edge. An allocation in the same cycle as a flush is dropped and leaves the allocation order unchanged. The allocation order otherwise survives a flush.
- R10: Reset invalidates every tag and restores the initial pair order of R6.
- R11: Every allocation, whether it starts a new pair or double-buffers within an owned pair, makes its pair the most recently allocated one in its bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Task-switch flush of all tags |
| dec_reg | input | REG_W (6) | Pointer-register field of the instruction in decode |
| dec_class | input | 2 | 00 other, 01 load/store, 10 jump, 11 other |
| alloc_en | input | 1 | Allocation request |
| alloc_fetch | input | 1 | Allocation bank: 1 fetch, 0 load/store |
| alloc_reg | input | REG_W (6) | Register number to tag the line with |
| alloc_addr | input | ADDR_W (27) | Line address to tag the line with |
| hit | output | 1 | Lookup hit |
| hit_line | output | 4 | Index of the hitting line |
| hit_addr | output | ADDR_W (27) | Address tag of the hitting line |
| issue_ok | output | 1 | Memory or jump instruction may issue |
| prefetch_req | output | 1 | Decode must generate a prefetch |
| victim_line | output | 4 | Line the current allocation request will fill |

## Verification
Lookups are tried from a table on one set of tags that places the same register in both banks, a register held twice within one pair, registers present in only one bank, and register 0. This separates bank selection by class, the choice between double-buffered lines, and the treatment of classes that do no search. Allocation sequences then repeat a register and introduce new ones, which exposes the alternation inside a pair, the least-recently-allocated pair order, eviction of the old owner, and invalidation of the partner line. A flush issued together with an allocation, followed by a reset, shows that the tags are cleared while the allocation order is kept across a flush and restored by reset.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  // Instruction class seen by the tag lookup
  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_MEM  = 2'b01,
    CLS_JUMP = 2'b10,
    CLS_RSVD = 2'b11
  } icls_e;

  localparam int unsigned NUM_BANKS = 2;   // 0: load/store, 1: fetch
endpackage

// File: rtl/lbt_match.sv
// Parallel comparison of one register number against every line tag.
module lbt_match #(
  parameter int unsigned LINES = 8,
  parameter int unsigned REG_W = 6
) (
  input  logic [LINES-1:0]            vld,
  input  logic [LINES-1:0][REG_W-1:0] tags,
  input  logic [REG_W-1:0]            key,
  output logic [LINES-1:0]            match
);
  for (genvar l = 0; l < LINES; l++) begin : g_cmp
    assign match[l] = vld[l] && (tags[l] == key);
  end
endmodule

// File: rtl/lbt_pair_lru.sv
// Age ranking of line pairs; age PAIRS-1 marks the least recently allocated.
module lbt_pair_lru #(
  parameter int unsigned PAIRS = 4,
  localparam int unsigned PW   = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [PW-1:0] touch_pair,
  output logic [PW-1:0] lru_pair
);
  logic [PAIRS-1:0][PW-1:0] age_q, age_d;

  always_comb begin
    age_d = age_q;
    for (int p = 0; p < PAIRS; p++) begin
      if (PW'(p) == touch_pair) begin
        age_d[p] = '0;
      end else if (age_q[p] < age_q[touch_pair]) begin
        age_d[p] = age_q[p] + PW'(1);
      end
    end
  end

  always_comb begin
    lru_pair = '0;
    for (int p = 0; p < PAIRS; p++) begin
      if (age_q[p] == PW'(PAIRS - 1)) begin
        lru_pair = PW'(p);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAIRS; p++) begin
        age_q[p] <= PW'(PAIRS - 1 - p);
      end
    end else if (touch) begin
      age_q <= age_d;
    end
  end
endmodule

// File: rtl/lbt_bank.sv
// One bank of tagged lines organised as pairs, with lookup and victim choice.
module lbt_bank #(
  parameter int unsigned LINES  = 8,
  parameter int unsigned REG_W  = 6,
  parameter int unsigned ADDR_W = 27,
  localparam int unsigned PAIRS = LINES / 2,
  localparam int unsigned LW    = $clog2(LINES),
  localparam int unsigned PW    = LW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              look_en,
  input  logic [REG_W-1:0]  look_reg,
  input  logic              alloc_en,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              hit,
  output logic [LW-1:0]     hit_idx,
  output logic [ADDR_W-1:0] hit_addr,
  output logic [LW-1:0]     victim_idx
);
  logic [LINES-1:0]             vld_q, vld_d;
  logic [LINES-1:0][REG_W-1:0]  reg_q, reg_d;
  logic [LINES-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [PAIRS-1:0]             mru_q, mru_d;

  logic [LINES-1:0] look_m, alloc_m;
  logic [LW-1:0]    look_idx;
  logic             owned;
  logic [PW-1:0]    own_pair, lru_pair, vpair;
  logic             wr;

  lbt_match #(.LINES(LINES), .REG_W(REG_W)) i_look_match (
    .vld(vld_q), .tags(reg_q), .key(look_reg), .match(look_m)
  );

  lbt_match #(.LINES(LINES), .REG_W(REG_W)) i_alloc_match (
    .vld(vld_q), .tags(reg_q), .key(alloc_reg), .match(alloc_m)
  );

  // Lookup: a register owns at most one pair, so at most one pair matches.
  always_comb begin
    look_idx = '0;
    for (int p = 0; p < PAIRS; p++) begin
      if (look_m[2*p] || look_m[2*p+1]) begin
        if (look_m[2*p] && look_m[2*p+1]) begin
          look_idx = {PW'(p), mru_q[p]};
        end else begin
          look_idx = {PW'(p), look_m[2*p+1]};
        end
      end
    end
  end

  assign hit      = look_en && (|look_m);
  assign hit_idx  = hit ? look_idx : '0;
  assign hit_addr = hit ? addr_q[look_idx] : '0;

  // Victim choice: owned pair alternates, otherwise even line of LRU pair.
  always_comb begin
    own_pair = '0;
    for (int p = 0; p < PAIRS; p++) begin
      if (alloc_m[2*p] || alloc_m[2*p+1]) begin
        own_pair = PW'(p);
      end
    end
  end

  assign owned      = |alloc_m;
  assign victim_idx = owned ? {own_pair, ~mru_q[own_pair]} : {lru_pair, 1'b0};
  assign vpair      = victim_idx[LW-1:1];
  assign wr         = alloc_en && !flush;

  lbt_pair_lru #(.PAIRS(PAIRS)) i_lru (
    .clk(clk), .rst_n(rst_n), .touch(wr), .touch_pair(vpair), .lru_pair(lru_pair)
  );

  // Next state
  always_comb begin
    vld_d  = vld_q;
    reg_d  = reg_q;
    addr_d = addr_q;
    mru_d  = mru_q;
    if (flush) begin
      vld_d = '0;
    end else if (alloc_en) begin
      vld_d[victim_idx]  = 1'b1;
      reg_d[victim_idx]  = alloc_reg;
      addr_d[victim_idx] = alloc_addr;
      mru_d[vpair]       = victim_idx[0];
      if (!owned) begin
        vld_d[{vpair, 1'b1}] = 1'b0;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush || wr) begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      addr_q <= '0;
      mru_q  <= '0;
    end else if (wr) begin
      reg_q  <= reg_d;
      addr_q <= addr_d;
      mru_q  <= mru_d;
    end
  end
endmodule

// File: rtl/lbt_tagstore.sv
// Top: load/store bank and fetch bank, class-steered lookup.
module lbt_tagstore
  import lbt_pkg::*;
#(
  parameter int unsigned LINES_PER_BANK = 8,
  parameter int unsigned REG_W          = 6,
  parameter int unsigned ADDR_W         = 27,
  localparam int unsigned LW            = $clog2(LINES_PER_BANK),
  localparam int unsigned IW            = LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [REG_W-1:0]  dec_reg,
  input  logic [1:0]        dec_class,
  input  logic              alloc_en,
  input  logic              alloc_fetch,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              hit,
  output logic [IW-1:0]     hit_line,
  output logic [ADDR_W-1:0] hit_addr,
  output logic              issue_ok,
  output logic              prefetch_req,
  output logic [IW-1:0]     victim_line
);
  logic is_mem, is_jump, needs_ptr;
  logic [NUM_BANKS-1:0]             bk_hit;
  logic [NUM_BANKS-1:0][LW-1:0]     bk_idx;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] bk_addr;
  logic [NUM_BANKS-1:0][LW-1:0]     bk_vic;

  assign is_mem    = (dec_class == CLS_MEM);
  assign is_jump   = (dec_class == CLS_JUMP);
  assign needs_ptr = is_mem || is_jump;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic look_en_b, alloc_en_b;
    assign look_en_b  = (b == 0) ? is_mem : is_jump;
    assign alloc_en_b = alloc_en && (alloc_fetch == (b != 0));

    lbt_bank #(
      .LINES(LINES_PER_BANK), .REG_W(REG_W), .ADDR_W(ADDR_W)
    ) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .look_en    (look_en_b),
      .look_reg   (dec_reg),
      .alloc_en   (alloc_en_b),
      .alloc_reg  (alloc_reg),
      .alloc_addr (alloc_addr),
      .hit        (bk_hit[b]),
      .hit_idx    (bk_idx[b]),
      .hit_addr   (bk_addr[b]),
      .victim_idx (bk_vic[b])
    );
  end

  assign hit          = |bk_hit;
  assign hit_line     = !hit    ? '0
                      : is_jump ? {1'b1, bk_idx[1]} : {1'b0, bk_idx[0]};
  assign hit_addr     = is_jump ? bk_addr[1] : bk_addr[0];
  assign issue_ok     = needs_ptr && hit;
  assign prefetch_req = needs_ptr && !hit;
  assign victim_line  = alloc_fetch ? {1'b1, bk_vic[1]} : {1'b0, bk_vic[0]};
endmodule

// File: rtl/lbt_tagstore_chk.sv
module lbt_tagstore_chk #(
  parameter int unsigned LINES_PER_BANK = 8,
  parameter int unsigned REG_W          = 6,
  parameter int unsigned ADDR_W         = 27,
  localparam int unsigned IW            = $clog2(LINES_PER_BANK) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [REG_W-1:0]  dec_reg,
  input logic [1:0]        dec_class,
  input logic              alloc_en,
  input logic              alloc_fetch,
  input logic [REG_W-1:0]  alloc_reg,
  input logic [ADDR_W-1:0] alloc_addr,
  input logic              hit,
  input logic [IW-1:0]     hit_line,
  input logic [ADDR_W-1:0] hit_addr,
  input logic              issue_ok,
  input logic              prefetch_req,
  input logic [IW-1:0]     victim_line
);
  a_r2_jump_in_fetch_half: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dec_class == 2'b10) |-> hit_line[IW-1]);

  a_r2_mem_in_ls_half: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dec_class == 2'b01) |-> !hit_line[IW-1]);

  a_r4_other_class_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_class == 2'b00 || dec_class == 2'b11) |-> (!hit && !issue_ok && !prefetch_req));

  a_r3_issue_xor_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_class == 2'b01 || dec_class == 2'b10) |-> (issue_ok != prefetch_req) && (issue_ok == hit));

  a_r5_victim_bank: assert property (@(posedge clk) disable iff (!rst_n)
    victim_line[IW-1] == alloc_fetch);

  a_r5_ls_alloc_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_class == 2'b01 && $past(alloc_en && !flush && !alloc_fetch) && dec_reg == $past(alloc_reg))
    |-> (hit && hit_line == $past(victim_line) && hit_addr == $past(alloc_addr)));

  a_r5_fetch_alloc_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_class == 2'b10 && $past(alloc_en && !flush && alloc_fetch) && dec_reg == $past(alloc_reg))
    |-> (hit && hit_line == $past(victim_line) && hit_addr == $past(alloc_addr)));

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);
endmodule

bind lbt_tagstore lbt_tagstore_chk #(
  .LINES_PER_BANK(LINES_PER_BANK), .REG_W(REG_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .dec_reg(dec_reg), .dec_class(dec_class),
  .alloc_en(alloc_en), .alloc_fetch(alloc_fetch), .alloc_reg(alloc_reg),
  .alloc_addr(alloc_addr), .hit(hit), .hit_line(hit_line), .hit_addr(hit_addr),
  .issue_ok(issue_ok), .prefetch_req(prefetch_req), .victim_line(victim_line)
);

// File: tb/test_lbt_tagstore.sv
module test_lbt_tagstore;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic [5:0]  dec_reg;
  logic [1:0]  dec_class;
  logic        alloc_en;
  logic        alloc_fetch;
  logic [5:0]  alloc_reg;
  logic [26:0] alloc_addr;
  logic        hit;
  logic [3:0]  hit_line;
  logic [26:0] hit_addr;
  logic        issue_ok;
  logic        prefetch_req;
  logic [3:0]  victim_line;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  lbt_tagstore i_lbt_tagstore (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dec_reg(dec_reg), .dec_class(dec_class),
    .alloc_en(alloc_en), .alloc_fetch(alloc_fetch), .alloc_reg(alloc_reg),
    .alloc_addr(alloc_addr), .hit(hit), .hit_line(hit_line), .hit_addr(hit_addr),
    .issue_ok(issue_ok), .prefetch_req(prefetch_req), .victim_line(victim_line)
  );

  // {class[41:40], reg[39:34], hit[33], line[32:29], issue[28], prefetch[27], addr[26:0]}
  localparam logic [41:0] VEC [0:8] = '{
    {2'b01, 6'd5,  1'b1, 4'd1,  1'b1, 1'b0, 27'h0000300},  // R8 double-buffered reg
    {2'b01, 6'd9,  1'b1, 4'd2,  1'b1, 1'b0, 27'h0000200},  // R1
    {2'b10, 6'd9,  1'b1, 4'd8,  1'b1, 1'b0, 27'h1000400},  // R2 fetch bank
    {2'b10, 6'd5,  1'b0, 4'd0,  1'b0, 1'b1, 27'h0},        // R2 R4 miss in fetch
    {2'b01, 6'd12, 1'b0, 4'd0,  1'b0, 1'b1, 27'h0},        // R2 R4 miss in ls
    {2'b10, 6'd12, 1'b1, 4'd10, 1'b1, 1'b0, 27'h1000600},  // R2 R3
    {2'b00, 6'd5,  1'b0, 4'd0,  1'b0, 1'b0, 27'h0},        // R4 other class
    {2'b11, 6'd9,  1'b0, 4'd0,  1'b0, 1'b0, 27'h0},        // R4 reserved class
    {2'b01, 6'd0,  1'b0, 4'd0,  1'b0, 1'b1, 27'h0}         // R1 R4 register 0
  };

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic look(input logic [1:0] cls, input logic [5:0] r);
    @(negedge clk);
    dec_class = cls;
    dec_reg   = r;
    #1;
  endtask

  task automatic do_alloc(input logic fetch, input logic [5:0] r, input logic [26:0] a,
                          input logic [3:0] exp_vic, input string rq);
    @(negedge clk);
    alloc_en    = 1'b1;
    alloc_fetch = fetch;
    alloc_reg   = r;
    alloc_addr  = a;
    #1;
    chk(rq, "victim_line", 64'(victim_line), 64'(exp_vic));
    @(posedge clk);
    #1;
    alloc_en = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; dec_reg = '0; dec_class = 2'b00;
    alloc_en = 1'b0; alloc_fetch = 1'b0; alloc_reg = '0; alloc_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    look(2'b01, 6'd5);
    chk("R10", "hit after reset", 64'(hit), 64'd0);
    chk("R4", "prefetch on miss", 64'(prefetch_req), 64'd1);

    // R5: allocation not visible before the edge
    @(negedge clk);
    alloc_en = 1'b1; alloc_fetch = 1'b0; alloc_reg = 6'd5; alloc_addr = 27'h100;
    #1;
    chk("R5", "hit before edge", 64'(hit), 64'd0);
    chk("R6", "victim first new reg", 64'(victim_line), 64'd0);
    @(posedge clk);
    #1 alloc_en = 1'b0;

    do_alloc(1'b0, 6'd9,  27'h0000200, 4'd2,  "R6");
    do_alloc(1'b0, 6'd5,  27'h0000300, 4'd1,  "R7");
    do_alloc(1'b1, 6'd9,  27'h1000400, 4'd8,  "R5");
    do_alloc(1'b1, 6'd12, 27'h1000600, 4'd10, "R6");

    // Lookup table: R1/R2/R3/R4/R8
    for (int i = 0; i < 9; i++) begin
      look(VEC[i][41:40], VEC[i][39:34]);
      chk("R1/R2/R8", "hit",      64'(hit),          64'(VEC[i][33]));
      chk("R1/R2/R8", "hit_line", 64'(hit_line),     64'(VEC[i][32:29]));
      chk("R3",       "issue_ok", 64'(issue_ok),     64'(VEC[i][28]));
      chk("R4",       "prefetch", 64'(prefetch_req), 64'(VEC[i][27]));
      chk("R1",       "hit_addr", 64'(hit_addr),     64'(VEC[i][26:0]));
    end

    // R7 alternation inside owned pair
    do_alloc(1'b0, 6'd5, 27'h0000500, 4'd0, "R7");
    look(2'b01, 6'd5);
    chk("R7", "line after alternation", 64'(hit_line), 64'd0);
    chk("R7", "addr after alternation", 64'(hit_addr), 64'h500);

    // R11 / R6: LRU pair order after repeated use of pair 0
    do_alloc(1'b0, 6'd20, 27'h0000700, 4'd4, "R11");
    do_alloc(1'b0, 6'd21, 27'h0000800, 4'd6, "R11");
    do_alloc(1'b0, 6'd22, 27'h0000900, 4'd2, "R11");
    look(2'b01, 6'd9);
    chk("R6", "evicted owner misses", 64'(hit), 64'd0);
    look(2'b01, 6'd22);
    chk("R6", "new owner line", 64'(hit_line), 64'd2);
    do_alloc(1'b0, 6'd23, 27'h0000a00, 4'd0, "R6");
    look(2'b01, 6'd5);
    chk("R6", "partner line invalidated", 64'(hit), 64'd0);

    // R9 flush with a simultaneous allocation
    @(negedge clk);
    flush = 1'b1; alloc_en = 1'b1; alloc_fetch = 1'b1; alloc_reg = 6'd30; alloc_addr = 27'h1000b00;
    @(posedge clk);
    #1 flush = 1'b0; alloc_en = 1'b0;
    look(2'b10, 6'd9);
    chk("R9", "fetch tag flushed", 64'(hit), 64'd0);
    look(2'b10, 6'd30);
    chk("R9", "alloc during flush dropped", 64'(hit), 64'd0);
    look(2'b01, 6'd22);
    chk("R9", "ls tag flushed", 64'(hit), 64'd0);
    do_alloc(1'b0, 6'd7, 27'h0000c00, 4'd4, "R9");
    do_alloc(1'b1, 6'd30, 27'h1000b00, 4'd12, "R9");
    look(2'b01, 6'd7);
    chk("R9", "alloc after flush", 64'(hit_line), 64'd4);

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    look(2'b01, 6'd7);
    chk("R10", "tags cleared by reset", 64'(hit), 64'd0);
    @(negedge clk);
    alloc_en = 1'b1; alloc_fetch = 1'b0; alloc_reg = 6'd40; alloc_addr = 27'h1;
    #1;
    chk("R10", "pair order restored", 64'(victim_line), 64'd0);
    alloc_en = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule